// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets host write cycles aimed at a byte-wide flash array model. Each clock cycle in which the write strobe is high carries one bus write, made of an address and a data byte. The decoder follows the unlock patterns that guard every command. Only a complete, exact sequence produces a request to the embedded-operation engine. A request is a one-cycle pulse that carries an operation code, the write address and the write data. The engine reports completion with a one-cycle `op_done` pulse. That pulse returns the decoder from its busy states to array read mode.

The decoder also controls the read path. It selects array data, identifier codes or engine status. In identifier mode it supplies the identifier byte for the low read-address bits.

States:
- `ST_IDLE`: array read.
- `ST_UNL1` and `ST_UNL2`: after the first and second unlock write.
- `ST_PROG_DATA`: awaiting the program address and data.
- `ST_ERS_SETUP`: after the erase set-up byte.
- `ST_ERS_UNL1` and `ST_ERS_UNL2`: the second unlock pair of an erase.
- `ST_AUTOSEL`: identifier mode.
- `ST_BUSY_PROG`, `ST_BUSY_CHIP` and `ST_BUSY_SECT`: engine running.
- `ST_SUSPENDED`: sector erase paused.

Transitions:
- Unlock advance (AAh to 555h, then 55h to 2AAh).
- Command dispatch (A0h, 80h or 90h to 555h).
- Program issue (any address and data).
- Erase unlock (AAh then 55h).
- Chip issue (10h to 555h).
- Sector issue (30h to any address).
- Suspend (B0h).
- Resume (30h).
- Reset (F0h).
- Abort (any other write inside a sequence).
- Completion (`op_done`).

Top module: `flash_cmd_decoder`

## Requirements
- R1: When `rst_n` is low, the decoder enters `ST_IDLE` with `rd_sel`=0 (array) and `req_valid`=0. Any partly entered sequence is forgotten, including one left in a busy state. A following write of A0h to 555h or a data write then issues nothing.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any address and data byte, issue exactly one request with `req_op`=1 (program). The request appears one cycle after the last write and carries that address and data. The three earlier writes issue no request. Unlock addresses are compared on `wr_addr[11:0]` only.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h issue `req_op`=2 (chip erase) on the sixth write only.
- R4: The same first five erase writes, followed by 30h at any address, issue `req_op`=3 (sector erase). `req_sector` equals `req_addr[20:16]`, so it selects one of 32 sectors of 64 KiB.
- R5: During a sector erase, B0h at any address issues `req_op`=4 (suspend) and enters `ST_SUSPENDED`. There, 30h issues `req_op`=5 (resume) and returns to `ST_BUSY_SECT`, and every other write is ignored. A further 30h after resuming is ignored, and a new B0h suspends again.
- R6: A write that does not match the expected address or data inside an unlock, set-up or command cycle returns the decoder to `ST_IDLE` without a request.
- R7: A write of F0h at any address in `ST_IDLE`, in any unlock, set-up or command-cycle state, or in `ST_AUTOSEL` issues `req_op`=7 (reset) and returns to array mode. The program data cycle is the exception: there, F0h is program data.
- R8: In `ST_BUSY_PROG` and `ST_BUSY_CHIP` every write is ignored, and in `ST_BUSY_SECT` every write except B0h is ignored. `op_done` in a busy state returns to `ST_IDLE`, and `op_done` takes precedence over a write in the same cycle.
- R9: The writes AAh@555h, 55h@2AAh and 90h@555h issue `req_op`=6 (autoselect) and set `rd_sel`=1. In that mode `id_byte` is 04h for `rd_addr_lo`=0, ADHh for 1 and 00h otherwise, and both codes have odd parity. Only F0h leaves the mode. `id_byte` is 00h in every other mode.
- R10: `rd_sel` is 2 (status) in the three busy states, 0 (array) in `ST_SUSPENDED` and every non-busy state other than autoselect, and 1 only in `ST_AUTOSEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | 21 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| op_done | input | 1 | Engine finished its operation (pulse) |
| rd_addr_lo | input | 2 | Low read-address bits selecting an identifier |
| req_valid | output | 1 | One-cycle request to the engine |
| req_op | output | 3 | Request code: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 autoselect, 7 reset |
| req_addr | output | 21 | Address of the write that issued the request |
| req_data | output | 8 | Data of the write that issued the request |
| req_sector | output | 5 | Sector index taken from `req_addr` |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_byte | output | 8 | Identifier byte for the read path |

## Verification
The assertions check, on every cycle, a set of relations between requests and modes:
- A request always follows a write.
- A busy state lets only a suspend out.
- Completion returns the decoder to array read.
- Program and erase requests coincide with status mode.
- Suspend and reset requests coincide with array mode.
- Resume follows a suspended cycle.
- Identifier bytes keep odd parity.

Only the directed scenarios can show the sequence content itself:
- The exact six-cycle erase pattern.
- Aborts on a wrong address or data byte.
- Repeated resume writes being dropped.
- The sector index.
- A hardware reset clearing a half-entered sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG_DATA,
        ST_ERS_SETUP,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_AUTOSEL,
        ST_BUSY_PROG,
        ST_BUSY_CHIP,
        ST_BUSY_SECT,
        ST_SUSPENDED
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROGRAM    = 3'd1,
        OP_CHIP_ERASE = 3'd2,
        OP_SECT_ERASE = 3'd3,
        OP_SUSPEND    = 3'd4,
        OP_RESUME     = 3'd5,
        OP_AUTOSEL    = 3'd6,
        OP_RESET      = 3'd7
    } op_code_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_ID     = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    // command byte values
    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_SETUP    = 8'h80;
    localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECT_RES = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

    // decoded view of one bus write
    typedef struct packed {
        logic any;
        logic reset;
        logic unl_a;
        logic unl_b;
        logic prog;
        logic setup;
        logic autosel;
        logic chip;
        logic sect;
        logic susp;
    } cyc_flags_t;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import fcd_pkg::*;
#(
    parameter int              DATA_W        = 8,
    parameter int              CMP_W         = 12,
    parameter logic [CMP_W-1:0] UNLOCK_ADDR_A = 'h555,
    parameter logic [CMP_W-1:0] UNLOCK_ADDR_B = 'h2AA
) (
    input  logic              wr_en,
    input  logic [CMP_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] wr_data,
    output cyc_flags_t        flags
);

    logic at_a;
    logic at_b;

    assign at_a = (addr_lo == UNLOCK_ADDR_A);
    assign at_b = (addr_lo == UNLOCK_ADDR_B);

    function automatic logic is_byte(input logic [DATA_W-1:0] d,
                                     input logic [7:0] code);
        return d == DATA_W'(code);
    endfunction

    always_comb begin
        flags         = '0;
        flags.any     = wr_en;
        flags.reset   = wr_en && is_byte(wr_data, CMD_RESET);
        flags.unl_a   = wr_en && at_a && is_byte(wr_data, CMD_UNLOCK_A);
        flags.unl_b   = wr_en && at_b && is_byte(wr_data, CMD_UNLOCK_B);
        flags.prog    = wr_en && at_a && is_byte(wr_data, CMD_PROGRAM);
        flags.setup   = wr_en && at_a && is_byte(wr_data, CMD_SETUP);
        flags.autosel = wr_en && at_a && is_byte(wr_data, CMD_AUTOSEL);
        flags.chip    = wr_en && at_a && is_byte(wr_data, CMD_CHIP);
        flags.sect    = wr_en && is_byte(wr_data, CMD_SECT_RES);
        flags.susp    = wr_en && is_byte(wr_data, CMD_SUSPEND);
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_flags_t        flags,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output seq_state_e        state,
    output logic              req_valid,
    output op_code_e          req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);

    seq_state_e nxt_state;
    logic       nxt_req;
    op_code_e   nxt_op;

    // next state and request decision
    always_comb begin
        nxt_state = state;
        nxt_req   = 1'b0;
        nxt_op    = OP_NONE;
        unique case (state)
            ST_IDLE: begin
                if (flags.reset) begin
                    nxt_req = 1'b1;
                    nxt_op  = OP_RESET;
                end else if (flags.unl_a) begin
                    nxt_state = ST_UNL1;
                end
            end
            ST_UNL1, ST_ERS_SETUP: begin
                if (flags.reset) begin
                    nxt_state = ST_IDLE;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_RESET;
                end else if (state == ST_UNL1 && flags.unl_b) begin
                    nxt_state = ST_UNL2;
                end else if (state == ST_ERS_SETUP && flags.unl_a) begin
                    nxt_state = ST_ERS_UNL1;
                end else if (flags.any) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_UNL2: begin
                if (flags.reset) begin
                    nxt_state = ST_IDLE;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_RESET;
                end else if (flags.prog) begin
                    nxt_state = ST_PROG_DATA;
                end else if (flags.setup) begin
                    nxt_state = ST_ERS_SETUP;
                end else if (flags.autosel) begin
                    nxt_state = ST_AUTOSEL;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_AUTOSEL;
                end else if (flags.any) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_PROG_DATA: begin
                if (flags.any) begin
                    nxt_state = ST_BUSY_PROG;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_PROGRAM;
                end
            end
            ST_ERS_UNL1: begin
                if (flags.reset) begin
                    nxt_state = ST_IDLE;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_RESET;
                end else if (flags.unl_b) begin
                    nxt_state = ST_ERS_UNL2;
                end else if (flags.any) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_ERS_UNL2: begin
                if (flags.reset) begin
                    nxt_state = ST_IDLE;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_RESET;
                end else if (flags.chip) begin
                    nxt_state = ST_BUSY_CHIP;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_CHIP_ERASE;
                end else if (flags.sect) begin
                    nxt_state = ST_BUSY_SECT;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_SECT_ERASE;
                end else if (flags.any) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_AUTOSEL: begin
                if (flags.reset) begin
                    nxt_state = ST_IDLE;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_RESET;
                end
            end
            ST_BUSY_PROG, ST_BUSY_CHIP: begin
                if (op_done) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_BUSY_SECT: begin
                if (op_done) begin
                    nxt_state = ST_IDLE;
                end else if (flags.susp) begin
                    nxt_state = ST_SUSPENDED;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_SUSPEND;
                end
            end
            ST_SUSPENDED: begin
                if (flags.sect) begin
                    nxt_state = ST_BUSY_SECT;
                    nxt_req   = 1'b1;
                    nxt_op    = OP_RESUME;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_op    <= OP_NONE;
            req_addr  <= '0;
            req_data  <= '0;
        end else begin
            req_valid <= nxt_req;
            req_op    <= nxt_op;
            if (nxt_req) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/fcd_read_ctrl.sv
module fcd_read_ctrl
    import fcd_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          ID_SEL_W = 2,
    parameter logic [7:0]  MFR_CODE = 8'h04,
    parameter logic [7:0]  DEV_CODE = 8'hAD
) (
    input  seq_state_e          state,
    input  logic [ID_SEL_W-1:0] rd_addr_lo,
    output rd_mode_e            rd_sel,
    output logic [DATA_W-1:0]   id_byte
);

    localparam int ID_SLOTS = 2 ** ID_SEL_W;

    logic [DATA_W-1:0] id_table [ID_SLOTS];

    for (genvar g = 0; g < ID_SLOTS; g++) begin : g_id
        if (g == 0) begin : g_mfr
            assign id_table[g] = DATA_W'(MFR_CODE);
        end else if (g == 1) begin : g_dev
            assign id_table[g] = DATA_W'(DEV_CODE);
        end else begin : g_blank
            assign id_table[g] = '0;
        end
    end

    always_comb begin
        unique case (state)
            ST_AUTOSEL:                             rd_sel = RD_ID;
            ST_BUSY_PROG, ST_BUSY_CHIP, ST_BUSY_SECT: rd_sel = RD_STATUS;
            default:                                rd_sel = RD_ARRAY;
        endcase
    end

    assign id_byte = (rd_sel == RD_ID) ? id_table[rd_addr_lo] : '0;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int DATA_W      = 8,
    parameter int NUM_SECTORS = 32,
    parameter int CMP_W       = 12,
    parameter int ID_SEL_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 op_done,
    input  logic [ID_SEL_W-1:0]  rd_addr_lo,
    output logic                 req_valid,
    output logic [2:0]           req_op,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [DATA_W-1:0]    req_data,
    output logic [$clog2(NUM_SECTORS)-1:0] req_sector,
    output logic [1:0]           rd_sel,
    output logic [DATA_W-1:0]    id_byte
);

    localparam int SECT_W = $clog2(NUM_SECTORS);

    cyc_flags_t flags;
    seq_state_e state;
    op_code_e   op_q;
    rd_mode_e   mode;

    fcd_cycle_match #(
        .DATA_W (DATA_W),
        .CMP_W  (CMP_W)
    ) u_match (
        .wr_en   (wr_en),
        .addr_lo (wr_addr[CMP_W-1:0]),
        .wr_data (wr_data),
        .flags   (flags)
    );

    fcd_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .op_done   (op_done),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .state     (state),
        .req_valid (req_valid),
        .req_op    (op_q),
        .req_addr  (req_addr),
        .req_data  (req_data)
    );

    fcd_read_ctrl #(
        .DATA_W   (DATA_W),
        .ID_SEL_W (ID_SEL_W)
    ) u_read (
        .state      (state),
        .rd_addr_lo (rd_addr_lo),
        .rd_sel     (mode),
        .id_byte    (id_byte)
    );

    assign req_op     = op_q;
    assign rd_sel     = mode;
    assign req_sector = req_addr[ADDR_W-1 -: SECT_W];

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       op_done,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [1:0] rd_sel,
    input logic [1:0] rd_addr_lo,
    input logic [7:0] id_byte
);

    // R6: a request never appears without a write in the cycle before
    p_req_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(wr_en));

    // R8: a busy state lets no request out except a suspend
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |=> (!req_valid || req_op == 3'd4));

    // R8: completion returns to array read
    p_done_to_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2 && op_done) |=> (rd_sel == 2'd0));

    // R10: program and erase requests coincide with status mode
    p_work_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd3))
        |-> (rd_sel == 2'd2));

    // R5: suspend reads the array, resume follows a suspended cycle
    p_suspend_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |-> (rd_sel == 2'd0));
    p_resume_from_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |-> (rd_sel == 2'd2 && $past(rd_sel) == 2'd0));

    // R7: a reset request leaves the decoder in array mode
    p_reset_array_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd7) |-> (rd_sel == 2'd0));

    // R9: identifier codes have odd parity
    p_id_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd1 && rd_addr_lo < 2'd2) |-> ($countones(id_byte) % 2 == 1));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .op_done    (op_done),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .rd_sel     (rd_sel),
    .rd_addr_lo (rd_addr_lo),
    .id_byte    (id_byte)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        op_done = 1'b0;
    logic [1:0]  rd_addr_lo = '0;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [20:0] req_addr;
    logic [7:0]  req_data;
    logic [4:0]  req_sector;
    logic [1:0]  rd_sel;
    logic [7:0]  id_byte;

    int n_chk = 0;
    int n_bad = 0;

    logic        got_v;
    logic [2:0]  got_op;
    logic [20:0] got_addr;
    logic [7:0]  got_data;
    logic [4:0]  got_sec;

    always #10 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .op_done(op_done), .rd_addr_lo(rd_addr_lo),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_sector(req_sector), .rd_sel(rd_sel),
        .id_byte(id_byte)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one bus write; captures the request one cycle later
    task automatic wr(input logic [20:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        got_v = req_valid; got_op = req_op; got_addr = req_addr;
        got_data = req_data; got_sec = req_sector;
    endtask

    task automatic unlock();
        wr(21'h555, 8'hAA);
        wr(21'h2AA, 8'h55);
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R1", "rd_sel after reset", rd_sel, 0);
        check("R1", "req_valid after reset", req_valid, 0);
        check("R9", "id_byte outside id mode", id_byte, 0);
    endtask

    task automatic t_program();
        unlock();
        check("R2", "no req on unlock", got_v, 0);
        wr(21'h555, 8'hA0);
        check("R2", "no req on A0", got_v, 0);
        wr(21'h12345, 8'h5A);
        check("R2", "program valid", got_v, 1);
        check("R2", "program op", got_op, 1);
        check("R2", "program addr", got_addr, 21'h12345);
        check("R2", "program data", got_data, 8'h5A);
        check("R10", "status while busy", rd_sel, 2);
        wr(21'h555, 8'hAA);
        check("R8", "busy ignores write", got_v, 0);
        wr(21'h000, 8'hF0);
        check("R8", "busy ignores F0", got_v, 0);
        check("R8", "still status", rd_sel, 2);
        done_pulse();
        check("R8", "done to array", rd_sel, 0);
        // F0 as program data is data
        unlock(); wr(21'h555, 8'hA0); wr(21'h00777, 8'hF0);
        check("R7", "F0 as program data op", got_op, 1);
        check("R7", "F0 program data", got_data, 8'hF0);
        done_pulse();
    endtask

    task automatic t_chip();
        unlock(); wr(21'h555, 8'h80);
        check("R3", "no req on setup", got_v, 0);
        unlock();
        check("R3", "no req on 2nd unlock", got_v, 0);
        wr(21'h555, 8'h10);
        check("R3", "chip valid", got_v, 1);
        check("R3", "chip op", got_op, 2);
        check("R3", "chip status", rd_sel, 2);
        wr(21'h000, 8'hB0);
        check("R8", "no suspend in chip erase", got_v, 0);
        done_pulse();
        check("R8", "chip done array", rd_sel, 0);
    endtask

    task automatic t_sector();
        unlock(); wr(21'h555, 8'h80); unlock();
        wr(21'h05ABCD, 8'h30);
        check("R4", "sector op", got_op, 3);
        check("R4", "sector index 5", got_sec, 5);
        done_pulse();
        unlock(); wr(21'h555, 8'h80); unlock();
        wr(21'h1F0000, 8'h30);
        check("R4", "sector index 31", got_sec, 31);
        wr(21'h000, 8'hB0);
        check("R5", "suspend op", got_op, 4);
        check("R5", "suspend valid", got_v, 1);
        check("R10", "array when suspended", rd_sel, 0);
        wr(21'h001234, 8'hAA);
        check("R5", "suspended ignores AA", got_v, 0);
        done_pulse();
        check("R5", "done ignored when suspended", rd_sel, 0);
        wr(21'h000, 8'h30);
        check("R5", "resume op", got_op, 5);
        check("R5", "resume status", rd_sel, 2);
        wr(21'h000, 8'h30);
        check("R5", "second resume ignored", got_v, 0);
        wr(21'h000, 8'hB0);
        check("R5", "re-suspend op", got_op, 4);
        wr(21'h000, 8'h30);
        check("R5", "re-resume op", got_op, 5);
        done_pulse();
        check("R8", "sector done array", rd_sel, 0);
    endtask

    task automatic t_abort();
        wr(21'h555, 8'hAA); wr(21'h2AB, 8'h55);
        check("R6", "bad addr no req", got_v, 0);
        wr(21'h555, 8'hA0);
        check("R6", "A0 after abort no req", got_v, 0);
        wr(21'h00100, 8'h11);
        check("R6", "data after abort no req", got_v, 0);
        check("R6", "array after abort", rd_sel, 0);
        unlock(); wr(21'h555, 8'h80); wr(21'h555, 8'hAA); wr(21'h2AA, 8'h54);
        check("R6", "bad erase unlock data", got_v, 0);
        wr(21'h555, 8'h10);
        check("R6", "chip cmd after abort ignored", got_v, 0);
        check("R6", "array after erase abort", rd_sel, 0);
    endtask

    task automatic t_f0();
        wr(21'h555, 8'hAA); wr(21'h000, 8'hF0);
        check("R7", "F0 mid unlock op", got_op, 7);
        check("R7", "F0 mid unlock array", rd_sel, 0);
        unlock(); wr(21'h555, 8'h80); wr(21'h123, 8'hF0);
        check("R7", "F0 after setup op", got_op, 7);
        wr(21'h000, 8'hF0);
        check("R7", "F0 in idle op", got_op, 7);
    endtask

    task automatic t_autosel();
        unlock(); wr(21'h555, 8'h90);
        check("R9", "autosel op", got_op, 6);
        check("R9", "id mode", rd_sel, 1);
        rd_addr_lo = 2'd0; #1;
        check("R9", "maker code", id_byte, 8'h04);
        rd_addr_lo = 2'd1; #1;
        check("R9", "device code", id_byte, 8'hAD);
        check("R9", "device parity odd", $countones(id_byte) % 2, 1);
        rd_addr_lo = 2'd2; #1;
        check("R9", "blank slot", id_byte, 8'h00);
        wr(21'h555, 8'hAA);
        check("R9", "id mode ignores AA", got_v, 0);
        check("R9", "still id mode", rd_sel, 1);
        wr(21'h000, 8'hF0);
        check("R9", "leave id op", got_op, 7);
        rd_addr_lo = 2'd1; #1;
        check("R9", "id zero after leave", id_byte, 8'h00);
    endtask

    task automatic t_hw_reset();
        unlock();
        hw_reset();
        check("R1", "array after mid reset", rd_sel, 0);
        wr(21'h555, 8'hA0);
        check("R1", "A0 after reset no req", got_v, 0);
        wr(21'h00042, 8'h99);
        check("R1", "data after reset no req", got_v, 0);
        unlock(); wr(21'h555, 8'hA0); wr(21'h00010, 8'h01);
        check("R1", "busy before reset", rd_sel, 2);
        hw_reset();
        check("R1", "reset leaves busy", rd_sel, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_chip();
        t_sector();
        t_abort();
        t_f0();
        t_autosel();
        t_hw_reset();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule